// File: doc/BRIEF.md
# Video Controller Register Bank

This block is the software-visible control and status bank of a display and drawing controller. A processor reaches it over a halfword-wide bus that also accepts byte and word transfers. Control values written here (display and drawing enables, line compare, brightness levels, frame-cycle count, column-table indices, object-control words, palettes and backdrop colour) appear on dedicated output buses for the display and drawing engines. Status flags from those engines are packed into readable status words.

Interrupt sources raise pending bits through a set input. Software clears them by writing ones to a clear register, and the request line falls once nothing is left pending. Reads return combinationally in the cycle of the access, and writes take effect at the next clock edge. Two write flavours exist. An ordinary byte write is widened to a full halfword. A debug byte write touches only its own byte lane.

Top module: `vidctl_regbank`

## Requirements
- R1: Registers decode on address bits above bit 0. Offsets outside the map read 0x0000 and a write to them changes no register.
- R2: `acc_size_i`=2 (word) acts as two halfword accesses. The low half goes to the address and the high half to the address plus 2. A word read returns the second halfword in bits 31..16.
- R3: `acc_size_i`=0 (byte) reads return, zero-extended, bits 7..0 of the addressed halfword for an even address and bits 15..8 for an odd one.
- R4: With `acc_debug_i`=0, a byte write to an even address writes the halfword {0x00, byte}. A byte write to an odd address writes {byte, 0x00}. Both are full halfword writes.
- R5: With `acc_debug_i`=1, a byte write updates only the addressed lane: bits 7..0 for an even address, bits 15..8 for an odd one.
- R6: Interrupt enable at 0x5F802 stores only the bits of mask 0xE01F. Each bit of `int_set_i` sets the matching pending bit, which reads back at 0x5F800.
- R7: Writing 1s to 0x5F804 clears those pending bits. `irq_o` rises one cycle after a set event on an enabled bit. It stays high while anything is pending and drops in the cycle the pending register becomes zero.
- R8: Display control at 0x5F822 takes bits 10..8 (lock, servo enable, refresh enable) from the high lane and bit 1 (display enable) from the low lane. `disp_ctl_o` is {lock, servo, refresh, display}. Status at 0x5F820 reads bits 10..8 as that control, bits 7..2 as `disp_flags_i[5:0]`, and bit 1 as display enable.
- R9: Drawing control at 0x5F842 takes the line compare from bits 12..8 (high lane) and drawing enable from bit 1 (low lane). Status at 0x5F840 reads bit 15 as `draw_out_i`, bits 12..8 as `draw_line_i`, bit 4 as `draw_overtime_i`, bits 3..2 as `draw_fbusy_i` and bit 1 as drawing enable.
- R10: Each of the eight palettes at 0x5F860 + 2n holds bits 7..2 of a write. Bits 1..0 read zero, and a write without the low lane has no effect.
- R11: Writes keep 8 bits for brightness (0x5F824 + 2n, n<4), 4 bits for frame cycle (0x5F82E), 10 bits for object control (0x5F848 + 2n, n<4) and 2 bits for backdrop (0x5F870).
- R12: 0x5F844 always reads 2. The column table at 0x5F830 reads as {right, left}, with each byte written from its own lane.
- R13: Reset clears every register, the pending bits and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | Access strobe |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_debug_i | input | 1 | Debug access, selects lane-exact byte writes |
| acc_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_addr_i | input | 19 | Byte address |
| acc_wdata_i | input | 32 | Write data |
| acc_rdata_o | output | 32 | Read data, combinational |
| int_set_i | input | 16 | Per-bit interrupt set events |
| disp_flags_i | input | 6 | Frame clock, scan ready, four frame-buffer busy flags |
| draw_out_i | input | 1 | Drawing output-line flag |
| draw_line_i | input | 5 | Current drawing line counter |
| draw_overtime_i | input | 1 | Drawing overtime flag |
| draw_fbusy_i | input | 2 | Drawing frame-buffer busy flags |
| irq_o | output | 1 | Interrupt request |
| disp_ctl_o | output | 4 | {lock, servo, refresh, display enable} |
| draw_en_o | output | 1 | Drawing enable |
| line_cmp_o | output | 5 | Line compare value |
| brt_o | output | 32 | Four 8-bit brightness values, entry n at bits 8n+7..8n |
| frame_cyc_o | output | 4 | Frame-cycle count |
| cta_left_o | output | 8 | Left column-table index |
| cta_right_o | output | 8 | Right column-table index |
| obj_ctl_o | output | 40 | Four 10-bit object-control words |
| pal_o | output | 48 | Eight 6-bit palettes |
| backdrop_o | output | 2 | Backdrop colour |

## Verification
A wrong lane select or slot decode changes a stored value. That error shows on the next read of the same offset and, one cycle after the write edge, on the matching control output bus. A wrong pending update shows on `irq_o` one cycle after the set or clear event: the request stays high with nothing pending, or drops while a bit remains. Status packing errors are combinational and appear in the same cycle on `acc_rdata_o` when the status offset is read.

// File: rtl/vidctl_pkg.sv
package vidctl_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // byte offsets inside the controller window
  localparam logic [31:0] OFS_INTPND = 32'h5F800;
  localparam logic [31:0] OFS_INTENB = 32'h5F802;
  localparam logic [31:0] OFS_INTCLR = 32'h5F804;
  localparam logic [31:0] OFS_DPSTAT = 32'h5F820;
  localparam logic [31:0] OFS_DPCTL  = 32'h5F822;
  localparam logic [31:0] OFS_BRT0   = 32'h5F824;
  localparam logic [31:0] OFS_FRMCYC = 32'h5F82E;
  localparam logic [31:0] OFS_CTAB   = 32'h5F830;
  localparam logic [31:0] OFS_XPSTAT = 32'h5F840;
  localparam logic [31:0] OFS_XPCTL  = 32'h5F842;
  localparam logic [31:0] OFS_VER    = 32'h5F844;
  localparam logic [31:0] OFS_OBJ0   = 32'h5F848;
  localparam logic [31:0] OFS_PAL0   = 32'h5F860;
  localparam logic [31:0] OFS_BKCOL  = 32'h5F870;

  localparam logic [15:0] VERSION_VAL = 16'h0002;

  // one resolved write slot aimed at a register
  typedef struct packed {
    logic        hit;
    logic        lo;
    logic        hi;
    logic [15:0] d;
  } wsel_t;

  function automatic logic [31:0] hidx(logic [31:0] ofs);
    return ofs >> 1;
  endfunction

  // pick whichever of the two halfword slots targets this register
  function automatic wsel_t pick_slot(logic [1:0] we, logic [31:0] i0, logic [31:0] i1,
                                      logic [31:0] tgt, logic [15:0] d0, logic [15:0] d1,
                                      logic [1:0] lo, logic [1:0] hi);
    wsel_t r;
    r = '0;
    if (we[0] && i0 == tgt) begin
      r.hit = 1'b1; r.lo = lo[0]; r.hi = hi[0]; r.d = d0;
    end else if (we[1] && i1 == tgt) begin
      r.hit = 1'b1; r.lo = lo[1]; r.hi = hi[1]; r.d = d1;
    end
    return r;
  endfunction

  // replace enabled byte lanes, keeping only the implemented bits
  function automatic logic [15:0] lane_merge(logic [15:0] old, logic [15:0] d,
                                             logic [15:0] keep, logic lo, logic hi);
    logic [15:0] m;
    m = {{8{hi}}, {8{lo}}};
    return (old & ~m) | (d & keep & m);
  endfunction

  function automatic logic [15:0] pal_pack(logic [5:0] p);
    return {8'h00, p, 2'b00};
  endfunction

endpackage

// File: rtl/vidctl_access_split.sv
module vidctl_access_split
  import vidctl_pkg::*;
#(
  parameter int ADDR_W = 19,
  localparam int HW_W = ADDR_W - 1
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic              debug_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [1:0]        we_o,
  output logic [HW_W-1:0]   idx0_o,
  output logic [HW_W-1:0]   idx1_o,
  output logic [15:0]       wd0_o,
  output logic [15:0]       wd1_o,
  output logic [1:0]        lo_o,
  output logic [1:0]        hi_o
);
  logic is_byte, is_word, odd;

  assign is_byte = (size_i == SZ_BYTE);
  assign is_word = (size_i == SZ_WORD);
  assign odd     = addr_i[0];

  assign idx0_o = addr_i[ADDR_W-1:1];
  assign idx1_o = addr_i[ADDR_W-1:1] + HW_W'(1);

  assign we_o[0] = valid_i && write_i;
  assign we_o[1] = valid_i && write_i && is_word;

  always_comb begin
    if (is_byte) wd0_o = odd ? {wdata_i[7:0], 8'h00} : {8'h00, wdata_i[7:0]};
    else         wd0_o = wdata_i[15:0];
  end
  assign wd1_o = wdata_i[31:16];

  // debug byte writes touch only the addressed lane
  assign lo_o[0] = !(is_byte && debug_i && odd);
  assign hi_o[0] = !(is_byte && debug_i && !odd);
  assign lo_o[1] = 1'b1;
  assign hi_o[1] = 1'b1;
endmodule

// File: rtl/vidctl_irq.sv
module vidctl_irq
  import vidctl_pkg::*;
#(
  parameter logic [15:0] ENB_MASK = 16'hE01F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  we_i,
  input  logic [31:0] idx0_i,
  input  logic [31:0] idx1_i,
  input  logic [15:0] wd0_i,
  input  logic [15:0] wd1_i,
  input  logic [1:0]  lo_i,
  input  logic [1:0]  hi_i,
  input  logic [15:0] int_set_i,
  output logic [15:0] inten_o,
  output logic [15:0] pend_o,
  output logic        irq_o
);
  wsel_t       enb_sel, clr_sel;
  logic [15:0] inten_q, pend_q, pend_next, clr_bits;
  logic        irq_q, irq_next;

  assign enb_sel = pick_slot(we_i, idx0_i, idx1_i, hidx(OFS_INTENB), wd0_i, wd1_i, lo_i, hi_i);
  assign clr_sel = pick_slot(we_i, idx0_i, idx1_i, hidx(OFS_INTCLR), wd0_i, wd1_i, lo_i, hi_i);

  assign clr_bits  = clr_sel.hit ? (clr_sel.d & {{8{clr_sel.hi}}, {8{clr_sel.lo}}}) : 16'h0000;
  assign pend_next = (pend_q & ~clr_bits) | int_set_i;
  assign irq_next  = (irq_q || |(int_set_i & inten_q)) && (pend_next != 16'h0000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inten_q <= '0;
      pend_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (enb_sel.hit)
        inten_q <= lane_merge(inten_q, enb_sel.d, ENB_MASK, enb_sel.lo, enb_sel.hi);
      pend_q <= pend_next;
      irq_q  <= irq_next;
    end
  end

  assign inten_o = inten_q;
  assign pend_o  = pend_q;
  assign irq_o   = irq_q;

  // R7
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == 16'h0000) |-> !irq_q);

  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bits != 16'h0000 && int_set_i == 16'h0000) |=> ((pend_q & $past(clr_bits)) == 16'h0000));
endmodule

// File: rtl/vidctl_ctrl_regs.sv
module vidctl_ctrl_regs
  import vidctl_pkg::*;
#(
  parameter int NUM_BRT = 4,
  parameter int NUM_OBJ = 4,
  parameter int NUM_PAL = 8,
  parameter int OBJ_W   = 10,
  parameter int FRM_W   = 4,
  parameter int BK_W    = 2,
  localparam logic [15:0] OBJ_KEEP = 16'((1 << OBJ_W) - 1),
  localparam logic [15:0] FRM_KEEP = 16'((1 << FRM_W) - 1),
  localparam logic [15:0] BK_KEEP  = 16'((1 << BK_W) - 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               we_i,
  input  logic [31:0]              idx0_i,
  input  logic [31:0]              idx1_i,
  input  logic [15:0]              wd0_i,
  input  logic [15:0]              wd1_i,
  input  logic [1:0]               lo_i,
  input  logic [1:0]               hi_i,
  output logic [3:0]               dp_ctl_o,
  output logic                     draw_en_o,
  output logic [4:0]               line_cmp_o,
  output logic [NUM_BRT*8-1:0]     brt_o,
  output logic [FRM_W-1:0]         frame_o,
  output logic [7:0]               cta_l_o,
  output logic [7:0]               cta_r_o,
  output logic [NUM_OBJ*OBJ_W-1:0] obj_o,
  output logic [NUM_PAL*6-1:0]     pal_o,
  output logic [BK_W-1:0]          bk_o
);
  wsel_t dp_sel, xp_sel, frm_sel, cta_sel, bk_sel;
  logic [3:0]       dp_q;
  logic             xp_en_q;
  logic [4:0]       lcmp_q;
  logic [FRM_W-1:0] frm_q;
  logic [7:0]       cta_l_q, cta_r_q;
  logic [BK_W-1:0]  bk_q;
  logic [15:0]      frm_nv, bk_nv;

  assign dp_sel  = pick_slot(we_i, idx0_i, idx1_i, hidx(OFS_DPCTL),  wd0_i, wd1_i, lo_i, hi_i);
  assign xp_sel  = pick_slot(we_i, idx0_i, idx1_i, hidx(OFS_XPCTL),  wd0_i, wd1_i, lo_i, hi_i);
  assign frm_sel = pick_slot(we_i, idx0_i, idx1_i, hidx(OFS_FRMCYC), wd0_i, wd1_i, lo_i, hi_i);
  assign cta_sel = pick_slot(we_i, idx0_i, idx1_i, hidx(OFS_CTAB),   wd0_i, wd1_i, lo_i, hi_i);
  assign bk_sel  = pick_slot(we_i, idx0_i, idx1_i, hidx(OFS_BKCOL),  wd0_i, wd1_i, lo_i, hi_i);

  assign frm_nv = lane_merge(16'(frm_q), frm_sel.d, FRM_KEEP, frm_sel.lo, frm_sel.hi);
  assign bk_nv  = lane_merge(16'(bk_q),  bk_sel.d,  BK_KEEP,  bk_sel.lo,  bk_sel.hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_q    <= '0;
      xp_en_q <= 1'b0;
      lcmp_q  <= '0;
      frm_q   <= '0;
      cta_l_q <= '0;
      cta_r_q <= '0;
      bk_q    <= '0;
    end else begin
      if (dp_sel.hit && dp_sel.hi) dp_q[3:1] <= dp_sel.d[10:8];
      if (dp_sel.hit && dp_sel.lo) dp_q[0]   <= dp_sel.d[1];
      if (xp_sel.hit && xp_sel.hi) lcmp_q    <= xp_sel.d[12:8];
      if (xp_sel.hit && xp_sel.lo) xp_en_q   <= xp_sel.d[1];
      if (frm_sel.hit) frm_q <= frm_nv[FRM_W-1:0];
      if (cta_sel.hit && cta_sel.hi) cta_r_q <= cta_sel.d[15:8];
      if (cta_sel.hit && cta_sel.lo) cta_l_q <= cta_sel.d[7:0];
      if (bk_sel.hit) bk_q <= bk_nv[BK_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_BRT; g++) begin : g_brt
    wsel_t       s;
    logic [7:0]  q;
    logic [15:0] nv;
    assign s  = pick_slot(we_i, idx0_i, idx1_i, hidx(OFS_BRT0 + 32'(2 * g)), wd0_i, wd1_i, lo_i, hi_i);
    assign nv = lane_merge({8'h00, q}, s.d, 16'h00FF, s.lo, s.hi);
    always_ff @(posedge clk) begin
      if (!rst_n)     q <= '0;
      else if (s.hit) q <= nv[7:0];
    end
    assign brt_o[g*8 +: 8] = q;
  end

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    wsel_t            s;
    logic [OBJ_W-1:0] q;
    logic [15:0]      nv;
    assign s  = pick_slot(we_i, idx0_i, idx1_i, hidx(OFS_OBJ0 + 32'(2 * g)), wd0_i, wd1_i, lo_i, hi_i);
    assign nv = lane_merge(16'(q), s.d, OBJ_KEEP, s.lo, s.hi);
    always_ff @(posedge clk) begin
      if (!rst_n)     q <= '0;
      else if (s.hit) q <= nv[OBJ_W-1:0];
    end
    assign obj_o[g*OBJ_W +: OBJ_W] = q;
  end

  for (genvar g = 0; g < NUM_PAL; g++) begin : g_pal
    wsel_t      s;
    logic [5:0] q;
    assign s = pick_slot(we_i, idx0_i, idx1_i, hidx(OFS_PAL0 + 32'(2 * g)), wd0_i, wd1_i, lo_i, hi_i);
    always_ff @(posedge clk) begin
      if (!rst_n)            q <= '0;
      else if (s.hit && s.lo) q <= s.d[7:2];
    end
    assign pal_o[g*6 +: 6] = q;
  end

  assign dp_ctl_o   = dp_q;
  assign draw_en_o  = xp_en_q;
  assign line_cmp_o = lcmp_q;
  assign frame_o    = frm_q;
  assign cta_l_o    = cta_l_q;
  assign cta_r_o    = cta_r_q;
  assign bk_o       = bk_q;

  // R1
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i == 2'b00) |=> $stable({dp_q, xp_en_q, lcmp_q, frm_q, cta_l_q, cta_r_q, bk_q, brt_o, obj_o, pal_o}));

  // R5
  lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cta_sel.hit && !cta_sel.hi) |=> $stable(cta_r_q));
endmodule

// File: rtl/vidctl_readback.sv
module vidctl_readback
  import vidctl_pkg::*;
#(
  parameter int NUM_BRT = 4,
  parameter int NUM_OBJ = 4,
  parameter int NUM_PAL = 8,
  parameter int OBJ_W   = 10,
  parameter int FRM_W   = 4,
  parameter int BK_W    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [31:0]              idx0_i,
  input  logic [31:0]              idx1_i,
  input  logic [1:0]               size_i,
  input  logic                     odd_i,
  input  logic [15:0]              inten_i,
  input  logic [15:0]              pend_i,
  input  logic [3:0]               dp_ctl_i,
  input  logic [5:0]               disp_flags_i,
  input  logic                     draw_en_i,
  input  logic                     draw_out_i,
  input  logic [4:0]               draw_line_i,
  input  logic                     draw_ovt_i,
  input  logic [1:0]               draw_fbusy_i,
  input  logic [NUM_BRT*8-1:0]     brt_i,
  input  logic [FRM_W-1:0]         frame_i,
  input  logic [7:0]               cta_l_i,
  input  logic [7:0]               cta_r_i,
  input  logic [NUM_OBJ*OBJ_W-1:0] obj_i,
  input  logic [NUM_PAL*6-1:0]     pal_i,
  input  logic [BK_W-1:0]          bk_i,
  output logic [31:0]              rdata_o
);
  logic [15:0] dp_stat, xp_stat, rv0, rv1;

  assign dp_stat = {5'b0, dp_ctl_i[3:1], disp_flags_i, dp_ctl_i[0], 1'b0};
  assign xp_stat = {draw_out_i, 2'b0, draw_line_i, 3'b0, draw_ovt_i, draw_fbusy_i, draw_en_i, 1'b0};

  function automatic logic [15:0] hw_read(logic [31:0] i);
    logic [15:0] v;
    v = 16'h0000;
    if      (i == hidx(OFS_INTPND)) v = pend_i;
    else if (i == hidx(OFS_INTENB)) v = inten_i;
    else if (i == hidx(OFS_DPSTAT)) v = dp_stat;
    else if (i == hidx(OFS_FRMCYC)) v = 16'(frame_i);
    else if (i == hidx(OFS_CTAB))   v = {cta_r_i, cta_l_i};
    else if (i == hidx(OFS_XPSTAT)) v = xp_stat;
    else if (i == hidx(OFS_VER))    v = VERSION_VAL;
    else if (i == hidx(OFS_BKCOL))  v = 16'(bk_i);
    for (int k = 0; k < NUM_BRT; k++)
      if (i == hidx(OFS_BRT0 + 32'(2 * k))) v = {8'h00, brt_i[k*8 +: 8]};
    for (int k = 0; k < NUM_OBJ; k++)
      if (i == hidx(OFS_OBJ0 + 32'(2 * k))) v = 16'(obj_i[k*OBJ_W +: OBJ_W]);
    for (int k = 0; k < NUM_PAL; k++)
      if (i == hidx(OFS_PAL0 + 32'(2 * k))) v = pal_pack(pal_i[k*6 +: 6]);
    return v;
  endfunction

  assign rv0 = hw_read(idx0_i);
  assign rv1 = hw_read(idx1_i);

  always_comb begin
    case (size_i)
      SZ_BYTE: rdata_o = {24'h0, odd_i ? rv0[15:8] : rv0[7:0]};
      SZ_WORD: rdata_o = {rv1, rv0};
      default: rdata_o = {16'h0, rv0};
    endcase
  end

  // R3
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_i == SZ_BYTE) |-> (rdata_o[31:8] == 24'h0));
endmodule

// File: rtl/vidctl_regbank.sv
module vidctl_regbank
  import vidctl_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int NUM_BRT = 4,
  parameter int NUM_OBJ = 4,
  parameter int NUM_PAL = 8,
  parameter int OBJ_W   = 10,
  parameter int FRM_W   = 4,
  parameter int BK_W    = 2,
  localparam int HW_W   = ADDR_W - 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_valid_i,
  input  logic                     acc_write_i,
  input  logic                     acc_debug_i,
  input  logic [1:0]               acc_size_i,
  input  logic [ADDR_W-1:0]        acc_addr_i,
  input  logic [31:0]              acc_wdata_i,
  output logic [31:0]              acc_rdata_o,
  input  logic [15:0]              int_set_i,
  input  logic [5:0]               disp_flags_i,
  input  logic                     draw_out_i,
  input  logic [4:0]               draw_line_i,
  input  logic                     draw_overtime_i,
  input  logic [1:0]               draw_fbusy_i,
  output logic                     irq_o,
  output logic [3:0]               disp_ctl_o,
  output logic                     draw_en_o,
  output logic [4:0]               line_cmp_o,
  output logic [NUM_BRT*8-1:0]     brt_o,
  output logic [FRM_W-1:0]         frame_cyc_o,
  output logic [7:0]               cta_left_o,
  output logic [7:0]               cta_right_o,
  output logic [NUM_OBJ*OBJ_W-1:0] obj_ctl_o,
  output logic [NUM_PAL*6-1:0]     pal_o,
  output logic [BK_W-1:0]          backdrop_o
);
  logic [1:0]      we, lo, hi;
  logic [HW_W-1:0] idx0, idx1;
  logic [31:0]     idx0_w, idx1_w;
  logic [15:0]     wd0, wd1, inten, pend;

  vidctl_access_split #(.ADDR_W(ADDR_W)) u_split (
    .valid_i(acc_valid_i), .write_i(acc_write_i), .debug_i(acc_debug_i),
    .size_i(acc_size_i), .addr_i(acc_addr_i), .wdata_i(acc_wdata_i),
    .we_o(we), .idx0_o(idx0), .idx1_o(idx1), .wd0_o(wd0), .wd1_o(wd1),
    .lo_o(lo), .hi_o(hi)
  );

  assign idx0_w = 32'(idx0);
  assign idx1_w = 32'(idx1);

  vidctl_irq u_irq (
    .clk(clk), .rst_n(rst_n), .we_i(we), .idx0_i(idx0_w), .idx1_i(idx1_w),
    .wd0_i(wd0), .wd1_i(wd1), .lo_i(lo), .hi_i(hi), .int_set_i(int_set_i),
    .inten_o(inten), .pend_o(pend), .irq_o(irq_o)
  );

  vidctl_ctrl_regs #(
    .NUM_BRT(NUM_BRT), .NUM_OBJ(NUM_OBJ), .NUM_PAL(NUM_PAL),
    .OBJ_W(OBJ_W), .FRM_W(FRM_W), .BK_W(BK_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(we), .idx0_i(idx0_w), .idx1_i(idx1_w),
    .wd0_i(wd0), .wd1_i(wd1), .lo_i(lo), .hi_i(hi),
    .dp_ctl_o(disp_ctl_o), .draw_en_o(draw_en_o), .line_cmp_o(line_cmp_o),
    .brt_o(brt_o), .frame_o(frame_cyc_o), .cta_l_o(cta_left_o), .cta_r_o(cta_right_o),
    .obj_o(obj_ctl_o), .pal_o(pal_o), .bk_o(backdrop_o)
  );

  vidctl_readback #(
    .NUM_BRT(NUM_BRT), .NUM_OBJ(NUM_OBJ), .NUM_PAL(NUM_PAL),
    .OBJ_W(OBJ_W), .FRM_W(FRM_W), .BK_W(BK_W)
  ) u_read (
    .clk(clk), .rst_n(rst_n), .idx0_i(idx0_w), .idx1_i(idx1_w),
    .size_i(acc_size_i), .odd_i(acc_addr_i[0]),
    .inten_i(inten), .pend_i(pend), .dp_ctl_i(disp_ctl_o), .disp_flags_i(disp_flags_i),
    .draw_en_i(draw_en_o), .draw_out_i(draw_out_i), .draw_line_i(draw_line_i),
    .draw_ovt_i(draw_overtime_i), .draw_fbusy_i(draw_fbusy_i),
    .brt_i(brt_o), .frame_i(frame_cyc_o), .cta_l_i(cta_left_o), .cta_r_i(cta_right_o),
    .obj_i(obj_ctl_o), .pal_i(pal_o), .bk_i(backdrop_o), .rdata_o(acc_rdata_o)
  );
endmodule

// File: tb/tb_vidctl_regbank.sv
module tb_vidctl_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0, debug = 1'b0;
  logic [1:0]  size = 2'd1;
  logic [18:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [15:0] int_set = '0;
  logic [5:0]  dflags = '0;
  logic        dout = 1'b0, dovt = 1'b0;
  logic [4:0]  dline = '0;
  logic [1:0]  dfb = '0;
  logic        irq, draw_en;
  logic [3:0]  dctl, frm;
  logic [4:0]  lcmp;
  logic [31:0] brt;
  logic [7:0]  ctl, ctr;
  logic [39:0] obj;
  logic [47:0] pal;
  logic [1:0]  bk;

  int errors = 0, checks = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  vidctl_regbank dut (
    .clk(clk), .rst_n(rst_n), .acc_valid_i(valid), .acc_write_i(write), .acc_debug_i(debug),
    .acc_size_i(size), .acc_addr_i(addr), .acc_wdata_i(wdata), .acc_rdata_o(rdata),
    .int_set_i(int_set), .disp_flags_i(dflags), .draw_out_i(dout), .draw_line_i(dline),
    .draw_overtime_i(dovt), .draw_fbusy_i(dfb), .irq_o(irq), .disp_ctl_o(dctl),
    .draw_en_o(draw_en), .line_cmp_o(lcmp), .brt_o(brt), .frame_cyc_o(frm),
    .cta_left_o(ctl), .cta_right_o(ctr), .obj_ctl_o(obj), .pal_o(pal), .backdrop_o(bk)
  );

  // {req, write addr, write value, read addr, expected halfword}
  localparam int NV = 14;
  localparam logic [73:0] VEC [NV] = '{
    {4'd6,  19'h5F802, 16'hFFFF, 19'h5F802, 16'hE01F},  // R6 enable mask
    {4'd11, 19'h5F82E, 16'hFFFF, 19'h5F82E, 16'h000F},  // R11 frame cycle
    {4'd11, 19'h5F848, 16'hFFFF, 19'h5F848, 16'h03FF},  // R11 object control
    {4'd11, 19'h5F84E, 16'h1234, 19'h5F84E, 16'h0234},  // R11
    {4'd11, 19'h5F870, 16'hFFFF, 19'h5F870, 16'h0003},  // R11 backdrop
    {4'd11, 19'h5F824, 16'h12AB, 19'h5F824, 16'h00AB},  // R11 brightness
    {4'd10, 19'h5F860, 16'hFFFF, 19'h5F860, 16'h00FC},  // R10 palette
    {4'd10, 19'h5F86E, 16'h00A5, 19'h5F86E, 16'h00A4},  // R10
    {4'd12, 19'h5F830, 16'hBEEF, 19'h5F830, 16'hBEEF},  // R12 column table
    {4'd12, 19'h5F844, 16'hFFFF, 19'h5F844, 16'h0002},  // R12 version
    {4'd8,  19'h5F822, 16'hFFFF, 19'h5F820, 16'h0702},  // R8 display control
    {4'd9,  19'h5F842, 16'hFFFF, 19'h5F840, 16'h0002},  // R9 drawing control
    {4'd1,  19'h5F900, 16'hFFFF, 19'h5F900, 16'h0000},  // R1 unmapped
    {4'd1,  19'h5F872, 16'hFFFF, 19'h5F872, 16'h0000}   // R1 unmapped
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sz, input logic [18:0] a, input logic [31:0] d, input logic dbg);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; size = sz; addr = a; wdata = d; debug = dbg;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; debug = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sz, input logic [18:0] a, output logic [31:0] d);
    valid = 1'b1; write = 1'b0; size = sz; addr = a;
    #0.5;
    d = rdata;
    valid = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] s);
    @(negedge clk); int_set = s;
    @(negedge clk); int_set = '0;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    rd(2'd1, 19'h5F802, v); check("R13 enable", v, 32'h0);
    rd(2'd1, 19'h5F800, v); check("R13 pending", v, 32'h0);
    check("R13 irq", {31'h0, irq}, 32'h0);
    check("R13 display ctl", {28'h0, dctl}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(2'd1, VEC[i][69:51], {16'h0, VEC[i][50:35]}, 1'b0);
      rd(2'd1, VEC[i][34:16], v);
      checks++;
      if (v[15:0] !== VEC[i][15:0]) begin
        errors++;
        $display("FAIL R%0d table %0d: actual=%h expected=%h", VEC[i][73:70], i, v[15:0], VEC[i][15:0]);
      end
    end

    // R8 port and status packing
    check("R8 disp_ctl_o", {28'h0, dctl}, 32'hF);
    dflags = 6'b101101;
    @(negedge clk); rd(2'd1, 19'h5F820, v); check("R8 status flags", v, 32'h07B6);
    dflags = '0;
    // R9 status packing and compare port
    dout = 1'b1; dline = 5'h15; dovt = 1'b1; dfb = 2'b10;
    @(negedge clk); rd(2'd1, 19'h5F840, v); check("R9 status", v, 32'h951A);
    dout = 1'b0; dline = '0; dovt = 1'b0; dfb = '0;
    check("R9 line_cmp_o", {27'h0, lcmp}, 32'h1F);

    // R5 debug even byte to display control clears only display enable
    wr(2'd0, 19'h5F822, 32'h0, 1'b1);
    rd(2'd1, 19'h5F820, v); check("R5 display lane", v, 32'h0700);

    // R4 normal byte writes become halfwords
    wr(2'd0, 19'h5F831, 32'h5A, 1'b0);
    rd(2'd1, 19'h5F830, v); check("R4 odd byte", v, 32'h5A00);
    wr(2'd0, 19'h5F830, 32'h77, 1'b0);
    rd(2'd1, 19'h5F830, v); check("R4 even byte", v, 32'h0077);

    // R5 debug odd byte keeps low lane
    wr(2'd1, 19'h5F830, 32'hBEEF, 1'b0);
    wr(2'd0, 19'h5F831, 32'h12, 1'b1);
    rd(2'd1, 19'h5F830, v); check("R5 column lane", v, 32'h12EF);
    check("R12 right port", {24'h0, ctr}, 32'h12);

    // R3 byte reads
    rd(2'd0, 19'h5F831, v); check("R3 odd byte read", v, 32'h12);
    rd(2'd0, 19'h5F830, v); check("R3 even byte read", v, 32'hEF);

    // R10 palette writes without the low lane
    wr(2'd1, 19'h5F860, 32'h0054, 1'b0);
    wr(2'd0, 19'h5F861, 32'hFF, 1'b1);
    rd(2'd1, 19'h5F860, v); check("R10 high-lane ignored", v, 32'h0054);
    check("R10 pal_o", {26'h0, pal[5:0]}, 32'h15);
    wr(2'd0, 19'h5F861, 32'hFF, 1'b0);
    rd(2'd1, 19'h5F860, v); check("R10 promoted odd byte", v, 32'h0000);

    // R2 word access
    wr(2'd2, 19'h5F848, 32'h015502AA, 1'b0);
    rd(2'd2, 19'h5F848, v); check("R2 word read", v, 32'h015502AA);
    check("R2 obj port", {12'h0, obj[19:0]}, 32'h556AA);

    // R6 R7 interrupts
    wr(2'd1, 19'h5F802, 32'h0003, 1'b0);
    pulse(16'h0004);
    check("R7 disabled source", {31'h0, irq}, 32'h0);
    rd(2'd1, 19'h5F800, v); check("R6 pending read", v, 32'h0004);
    wr(2'd1, 19'h5F804, 32'h0004, 1'b0);
    pulse(16'h0001);
    check("R7 irq rise", {31'h0, irq}, 32'h1);
    pulse(16'h8000);
    rd(2'd1, 19'h5F800, v); check("R6 pending two", v, 32'h8001);
    wr(2'd1, 19'h5F804, 32'h0001, 1'b0);
    check("R7 irq held", {31'h0, irq}, 32'h1);
    rd(2'd1, 19'h5F800, v); check("R7 partial clear", v, 32'h8000);
    wr(2'd1, 19'h5F804, 32'h8000, 1'b0);
    check("R7 irq drop", {31'h0, irq}, 32'h0);
    rd(2'd1, 19'h5F800, v); check("R7 all clear", v, 32'h0000);

    // R13 reset again
    pulse(16'h0001);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd1, 19'h5F802, v); check("R13 enable again", v, 32'h0);
    rd(2'd1, 19'h5F800, v); check("R13 pending again", v, 32'h0);
    rd(2'd1, 19'h5F830, v); check("R13 column table", v, 32'h0);
    rd(2'd1, 19'h5F820, v); check("R13 status", v, 32'h0);
    check("R13 irq again", {31'h0, irq}, 32'h0);
    check("R13 draw enable", {31'h0, draw_en}, 32'h0);
    report();
  end
endmodule